// File: doc/BRIEF.md
# Multi-Channel Rail Limit Guard

This block watches eleven monitored quantities (six supply rails, the core supply, the 12 V input, die temperature and two auxiliary inputs). Each arrives as a 10-bit sample tagged with its channel number. Every channel has four programmable limit words. Two are lower bounds and two are upper bounds. Each word carries a 10-bit threshold and four trigger flags. The flags say which system action a violation requests and whether the violation is critical.

A critical violation latches a per-channel fault bit. The fault bit stays set until the host clears it by writing 1 to it. The host reads the fault word through two byte-wide status registers in a separate status space. It programs the limits byte by byte in the limit space.

Four action outputs request reset, flag the system as unhealthy, request power-off and request shutdown. For every channel, the block keeps the flags of the limits that the channel's most recent sample violated. Each action output is the OR of that flag over all channels.

Top module: `rail_limit_guard`

## Requirements
- R1: After reset, all fault bits and all four action outputs are 0. Every lower-bound word reads 0x0000 and every upper-bound word reads 0x03FF.
- R2: When `bus_space`=0 (limit space), limit word k (k=0..3) of channel c occupies byte addresses 0x80+8c+2k (high byte) and 0x80+8c+2k+1 (low byte). Words 0 and 1 are lower bounds and words 2 and 3 are upper bounds. Addresses outside 0x80..0xD7 read 0, and writes to them change nothing.
- R3: A lower bound is violated only when the sample is strictly less than bits 9:0 of its word. A sample equal to the threshold is not a violation, and the flag bits take no part in the comparison.
- R4: An upper bound is violated only when the sample is strictly greater than bits 9:0 of its word. A sample equal to the threshold is not a violation.
- R5: A limit is critical when bit 15, bit 13 or bit 12 of its word is set. A critical violation sets the channel's fault bit on the next clock edge. A violation whose only flag is bit 14, or that has no flags, leaves the fault bits unchanged.
- R6: Fault bit i belongs to channel i (0..5 rails, 6 core supply, 7 12 V input, 8 temperature, 9 and 10 auxiliary). When `bus_space`=1, address 0x81 reads fault bits 15:8 and address 0x82 reads fault bits 7:0. Other status addresses read 0.
- R7: A fault bit stays set until the host writes 1 to its position through 0x81 or 0x82 in the status space. Written 0 bits have no effect. If a set and a clear reach the same bit in the same cycle, the set wins.
- R8: Each channel's action flags are refreshed on the clock edge that accepts its sample and hold until that channel's next sample. An action output is the OR over channels of the matching flag: bit 15 drives `act_reset`, bit 14 drives `act_unhealthy`, bit 13 drives `act_poweroff` and bit 12 drives `act_shutdown`.
- R9: A sample whose channel number is 11 or above changes neither the fault bits nor the action outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_space | input | 1 | 0 selects the limit space, 1 selects the status space |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address and space (combinational) |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | 4 | Channel number of the sample |
| smp_value | input | 10 | Sample value |
| act_reset | output | 1 | Reset request |
| act_unhealthy | output | 1 | System not healthy |
| act_poweroff | output | 1 | Power-off request |
| act_shutdown | output | 1 | Shutdown request |

## Verification
The assertions assume that a sample and a host write can arrive in the same cycle, and that a channel number can be out of range. They do not assume that the host reads back an address it has just written. The read-back property only constrains a cycle in which the address is held after a write. The stimulus drives all inputs half a cycle away from the sampling edge. It pulses each strobe for exactly one cycle, and it deliberately overlaps a sample with a clear of the same fault bit to exercise the set-over-clear rule.

// File: rtl/rlg_pkg.sv
package rlg_pkg;

    localparam int LIM_W     = 16;
    localparam int THR_W     = 10;
    localparam int STAT_W    = 16;
    localparam int F_RESET   = 15;
    localparam int F_HEALTH  = 14;
    localparam int F_POWER   = 13;
    localparam int F_SHUT    = 12;

    typedef logic [LIM_W-1:0] lim_word_t;
    typedef logic [THR_W-1:0] sample_t;

    typedef struct packed {
        logic rst_req;
        logic unhealthy;
        logic pwr_off;
        logic shut_dn;
    } act_t;

    typedef enum logic [0:0] {
        SPC_LIMIT  = 1'b0,
        SPC_STATUS = 1'b1
    } space_e;

    function automatic sample_t word_thr(lim_word_t w);
        return w[THR_W-1:0];
    endfunction

    function automatic act_t word_act(lim_word_t w);
        act_t a;
        a.rst_req   = w[F_RESET];
        a.unhealthy = w[F_HEALTH];
        a.pwr_off   = w[F_POWER];
        a.shut_dn   = w[F_SHUT];
        return a;
    endfunction

    function automatic logic word_crit(lim_word_t w);
        return w[F_RESET] | w[F_POWER] | w[F_SHUT];
    endfunction

    function automatic lim_word_t lim_default(int k, int n_under);
        if (k < n_under) return '0;
        return LIM_W'((2 ** THR_W) - 1);
    endfunction

endpackage

// File: rtl/rlg_limit_regs.sv
module rlg_limit_regs
    import rlg_pkg::*;
#(
    parameter int NUM_CH     = 11,
    parameter int LIM_PER_CH = 4,
    parameter int NUM_UNDER  = 2,
    parameter int ADDR_W     = 8,
    parameter int BASE_ADDR  = 'h80,
    localparam int CH_W      = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [CH_W-1:0]   sel_ch,
    output lim_word_t         sel_lims [LIM_PER_CH]
);

    localparam int K_W       = $clog2(LIM_PER_CH);
    localparam int SH        = K_W + 1;
    localparam int MAP_BYTES = NUM_CH * LIM_PER_CH * 2;

    lim_word_t lim_q [NUM_CH][LIM_PER_CH];

    logic [ADDR_W-1:0]    off;
    logic [ADDR_W-SH-1:0] ch_full;
    logic [CH_W-1:0]      acc_ch;
    logic [K_W-1:0]       acc_k;
    logic                 acc_lo;
    logic                 hit;

    assign off     = addr - ADDR_W'(BASE_ADDR);
    assign ch_full = off[ADDR_W-1:SH];
    assign acc_ch  = CH_W'(ch_full);
    assign acc_k   = off[SH-1:1];
    assign acc_lo  = off[0];
    assign hit     = ({1'b0, off} < (ADDR_W+1)'(MAP_BYTES));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CH; c++) begin
                for (int k = 0; k < LIM_PER_CH; k++) begin
                    lim_q[c][k] <= lim_default(k, NUM_UNDER);
                end
            end
        end else if (wr_en && hit) begin
            if (acc_lo) lim_q[acc_ch][acc_k][7:0]  <= wdata;
            else        lim_q[acc_ch][acc_k][15:8] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            if (acc_lo) rdata = lim_q[acc_ch][acc_k][7:0];
            else        rdata = lim_q[acc_ch][acc_k][15:8];
        end
    end

    logic sel_ok;
    assign sel_ok = ({1'b0, sel_ch} < (CH_W+1)'(NUM_CH));

    for (genvar k = 0; k < LIM_PER_CH; k++) begin : g_sel
        assign sel_lims[k] = sel_ok ? lim_q[sel_ch][k] : lim_default(k, NUM_UNDER);
    end

    // R2: a byte written to a mapped address reads back while the address is held
    p_readback_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hit) |=> ((addr != $past(addr)) || (rdata == $past(wdata))));

endmodule

// File: rtl/rlg_limit_cmp.sv
module rlg_limit_cmp
    import rlg_pkg::*;
#(
    parameter int LIM_PER_CH = 4,
    parameter int NUM_UNDER  = 2
) (
    input  sample_t                 sample,
    input  lim_word_t               lims [LIM_PER_CH],
    output logic [LIM_PER_CH-1:0]   viol,
    output act_t                    act,
    output logic                    crit
);

    for (genvar k = 0; k < LIM_PER_CH; k++) begin : g_cmp
        if (k < NUM_UNDER) begin : g_under
            assign viol[k] = (sample < word_thr(lims[k]));
        end else begin : g_over
            assign viol[k] = (sample > word_thr(lims[k]));
        end
    end

    always_comb begin
        act  = '0;
        crit = 1'b0;
        for (int k = 0; k < LIM_PER_CH; k++) begin
            if (viol[k]) begin
                act  = act | word_act(lims[k]);
                crit = crit | word_crit(lims[k]);
            end
        end
        // R5: a critical outcome needs at least one violated limit
        a_crit_needs_viol_r5: assert (!crit || (|viol));
    end

endmodule

// File: rtl/rlg_fault_track.sv
module rlg_fault_track
    import rlg_pkg::*;
#(
    parameter int NUM_CH = 11,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [CH_W-1:0]   smp_chan,
    input  act_t              hit_act,
    input  logic              hit_crit,
    input  logic              clr_en,
    input  logic [NUM_CH-1:0] clr_mask,
    output logic [NUM_CH-1:0] fault_q,
    output act_t              act_out
);

    act_t              ch_act [NUM_CH];
    logic              chan_ok;
    logic              take;
    logic [NUM_CH-1:0] set_mask;
    logic [NUM_CH-1:0] kill_mask;

    assign chan_ok   = ({1'b0, smp_chan} < (CH_W+1)'(NUM_CH));
    assign take      = smp_valid && chan_ok;
    assign set_mask  = (take && hit_crit) ? (NUM_CH'(1) << smp_chan) : '0;
    assign kill_mask = clr_en ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= '0;
        end else begin
            fault_q <= (fault_q & ~kill_mask) | set_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CH; c++) ch_act[c] <= '0;
        end else if (take) begin
            ch_act[smp_chan] <= hit_act;
        end
    end

    always_comb begin
        act_out = '0;
        for (int c = 0; c < NUM_CH; c++) act_out = act_out | ch_act[c];
    end

    // R5: a critical violation on a valid channel latches that channel's bit
    p_fault_set_r5: assert property (@(posedge clk) disable iff (rst)
        (take && hit_crit) |=> ((fault_q & $past(set_mask)) == $past(set_mask)));

    // R7: without a clear, no fault bit ever drops
    p_fault_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !clr_en |=> ((fault_q & $past(fault_q)) == $past(fault_q)));

    // R8: the action outputs move only after an accepted sample
    p_act_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(act_out));

    // R9: a sample on a channel that does not exist leaves the state alone
    p_bad_chan_r9: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !chan_ok && !clr_en) |=> ($stable(act_out) && $stable(fault_q)));

endmodule

// File: rtl/rail_limit_guard.sv
module rail_limit_guard
    import rlg_pkg::*;
#(
    parameter int NUM_CH       = 11,
    parameter int LIM_PER_CH   = 4,
    parameter int NUM_UNDER    = 2,
    parameter int ADDR_W       = 8,
    parameter int BASE_ADDR    = 'h80,
    parameter int STAT_HI_ADDR = 'h81,
    parameter int STAT_LO_ADDR = 'h82,
    localparam int CH_W        = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_space,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              smp_valid,
    input  logic [CH_W-1:0]   smp_chan,
    input  logic [THR_W-1:0]  smp_value,
    output logic              act_reset,
    output logic              act_unhealthy,
    output logic              act_poweroff,
    output logic              act_shutdown
);

    space_e            spc;
    logic [7:0]        lim_rdata;
    lim_word_t         cur_lims [LIM_PER_CH];
    logic [LIM_PER_CH-1:0] viol;
    act_t              hit_act;
    logic              hit_crit;
    logic [NUM_CH-1:0] fault_q;
    logic [STAT_W-1:0] fault16;
    logic [NUM_CH-1:0] clr_mask;
    logic              clr_en;
    logic              is_hi;
    logic              is_lo;
    act_t              act_out;

    assign spc     = space_e'(bus_space);
    assign is_hi   = (bus_addr == ADDR_W'(STAT_HI_ADDR));
    assign is_lo   = (bus_addr == ADDR_W'(STAT_LO_ADDR));
    assign clr_en  = bus_wr && (spc == SPC_STATUS) && (is_hi || is_lo);
    assign fault16 = STAT_W'(fault_q);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_clr
        if (i >= 8) begin : g_hi
            assign clr_mask[i] = is_hi && bus_wdata[i-8];
        end else begin : g_lo
            assign clr_mask[i] = is_lo && bus_wdata[i];
        end
    end

    rlg_limit_regs #(
        .NUM_CH     (NUM_CH),
        .LIM_PER_CH (LIM_PER_CH),
        .NUM_UNDER  (NUM_UNDER),
        .ADDR_W     (ADDR_W),
        .BASE_ADDR  (BASE_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr && (spc == SPC_LIMIT)),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (lim_rdata),
        .sel_ch   (smp_chan),
        .sel_lims (cur_lims)
    );

    rlg_limit_cmp #(
        .LIM_PER_CH (LIM_PER_CH),
        .NUM_UNDER  (NUM_UNDER)
    ) u_cmp (
        .sample (smp_value),
        .lims   (cur_lims),
        .viol   (viol),
        .act    (hit_act),
        .crit   (hit_crit)
    );

    rlg_fault_track #(
        .NUM_CH (NUM_CH)
    ) u_fault (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_chan  (smp_chan),
        .hit_act   (hit_act),
        .hit_crit  (hit_crit),
        .clr_en    (clr_en),
        .clr_mask  (clr_mask),
        .fault_q   (fault_q),
        .act_out   (act_out)
    );

    always_comb begin
        bus_rdata = '0;
        if (spc == SPC_LIMIT) begin
            bus_rdata = lim_rdata;
        end else if (is_hi) begin
            bus_rdata = fault16[15:8];
        end else if (is_lo) begin
            bus_rdata = fault16[7:0];
        end
    end

    assign act_reset     = act_out.rst_req;
    assign act_unhealthy = act_out.unhealthy;
    assign act_poweroff  = act_out.pwr_off;
    assign act_shutdown  = act_out.shut_dn;

endmodule

// File: tb/tb_rail_limit_guard.sv
module tb_rail_limit_guard;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_space = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       smp_valid = 1'b0;
    logic [3:0] smp_chan = '0;
    logic [9:0] smp_value = '0;
    logic       act_reset, act_unhealthy, act_poweroff, act_shutdown;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rail_limit_guard dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_space(bus_space),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_value(smp_value),
        .act_reset(act_reset), .act_unhealthy(act_unhealthy),
        .act_poweroff(act_poweroff), .act_shutdown(act_shutdown)
    );

    // entry: {chan[3:0], value[9:0], expected fault word[10:0], expected {rst,unhealthy,poweroff,shutdown}}
    localparam logic [28:0] VEC [NVEC] = '{
        {4'd0,  10'd100,  11'h000, 4'b0000},  // R3 equal to lower bound
        {4'd0,  10'd99,   11'h001, 4'b1000},  // R3 R5 critical lower violation
        {4'd0,  10'd500,  11'h001, 4'b0000},  // R7 sticky, R8 channel flags refresh
        {4'd0,  10'd901,  11'h001, 4'b0001},  // R4 above upper bound
        {4'd3,  10'd199,  11'h001, 4'b0101},  // R5 non-critical, R8 OR over channels
        {4'd0,  10'd900,  11'h001, 4'b0100},  // R4 equal to upper bound
        {4'd3,  10'd501,  11'h009, 4'b0010},  // R5 R6 bit 3
        {4'd10, 10'd1001, 11'h409, 4'b0111},  // R6 bit 10 in upper status byte
        {4'd12, 10'd0,    11'h409, 4'b0111},  // R9 channel out of range
        {4'd3,  10'd300,  11'h409, 4'b0101}   // R8 channel 3 back in range
    };

    task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expected);
        n_chk++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, actual, expected);
        end
    endtask

    task automatic bus_write(input logic spc, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_space = spc; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic spc, input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_space = spc; bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic write_word(input logic [7:0] a, input logic [15:0] w);
        bus_write(1'b0, a, w[15:8]);
        bus_write(1'b0, a + 8'd1, w[7:0]);
    endtask

    task automatic read_fault(output logic [15:0] f);
        logic [7:0] hi, lo;
        bus_read(1'b1, 8'h81, hi);
        bus_read(1'b1, 8'h82, lo);
        f = {hi, lo};
    endtask

    task automatic do_sample(input logic [3:0] c, input logic [9:0] v);
        @(negedge clk);
        smp_chan = c; smp_value = v; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    function automatic logic [3:0] acts();
        return {act_reset, act_unhealthy, act_poweroff, act_shutdown};
    endfunction

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] f;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        read_fault(f);
        chk("R1 fault after reset", f, 16'h0000);
        chk("R1 actions after reset", acts(), 4'b0000);
        bus_read(1'b0, 8'hAE, d); chk("R1 upper default hi", d, 8'h03);
        bus_read(1'b0, 8'hAF, d); chk("R1 upper default lo", d, 8'hFF);
        bus_read(1'b0, 8'hA8, d); chk("R1 lower default hi", d, 8'h00);

        // R2 program limits
        write_word(8'h80, 16'h8064);  // ch0 lower 0: 100, reset flag
        write_word(8'h84, 16'h1384);  // ch0 upper 2: 900, shutdown
        write_word(8'h9A, 16'h40C8);  // ch3 lower 1: 200, unhealthy only
        write_word(8'h9E, 16'h21F4);  // ch3 upper 3: 500, power-off
        write_word(8'hD4, 16'h53E8);  // ch10 upper 2: 1000, unhealthy+shutdown
        bus_read(1'b0, 8'h80, d); chk("R2 readback high byte", d, 8'h80);
        bus_read(1'b0, 8'h81, d); chk("R2 readback low byte", d, 8'h64);
        bus_read(1'b0, 8'hD5, d); chk("R2 last channel low byte", d, 8'hE8);
        bus_write(1'b0, 8'hD8, 8'h55);
        bus_read(1'b0, 8'hD8, d); chk("R2 write past map ignored", d, 8'h00);
        bus_read(1'b0, 8'h7F, d); chk("R2 below map reads zero", d, 8'h00);
        bus_read(1'b1, 8'h83, d); chk("R6 unused status address", d, 8'h00);

        // table of samples
        for (int i = 0; i < NVEC; i++) begin
            do_sample(VEC[i][28:25], VEC[i][24:15]);
            chk($sformatf("R8 actions vector %0d", i), acts(), VEC[i][3:0]);
            read_fault(f);
            chk($sformatf("R5 R6 fault vector %0d", i), f, {5'd0, VEC[i][14:4]});
        end

        // R7 write-one-to-clear
        bus_write(1'b1, 8'h82, 8'h08);
        read_fault(f); chk("R7 clear bit 3", f, 16'h0401);
        bus_write(1'b1, 8'h81, 8'h00);
        read_fault(f); chk("R7 zeros have no effect", f, 16'h0401);
        bus_write(1'b1, 8'h81, 8'h04);
        read_fault(f); chk("R7 clear bit 10", f, 16'h0001);
        chk("R7 clear leaves actions", acts(), 4'b0101);

        // R7 set wins over clear in the same cycle
        @(negedge clk);
        smp_chan = 4'd0; smp_value = 10'd0; smp_valid = 1'b1;
        bus_space = 1'b1; bus_addr = 8'h82; bus_wdata = 8'h01; bus_wr = 1'b1;
        chk("R8 no change before edge", acts(), 4'b0101);
        @(negedge clk);
        smp_valid = 1'b0; bus_wr = 1'b0;
        chk("R8 actions after sample edge", acts(), 4'b1101);
        read_fault(f); chk("R7 set beats clear", f, 16'h0001);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        read_fault(f); chk("R1 fault cleared by reset", f, 16'h0000);
        chk("R1 actions cleared by reset", acts(), 4'b0000);
        bus_read(1'b0, 8'h80, d); chk("R1 limit restored hi", d, 8'h00);
        bus_read(1'b0, 8'h84, d); chk("R1 upper restored hi", d, 8'h03);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule